// File: doc/BRIEF.md
# Multi-master I2C bus clock synchroniser

This block produces the SCL clock of one bus master on a shared open-drain line. It also keeps that clock in step with any other master driving the same wired-AND line. The block never drives the line high. It either pulls SCL low or lets it float, and it watches the actual line level through a two-stage synchroniser. Its local low-phase and high-phase timers restart on the bus edges it observes. As a result, the bus low time follows the slowest master and the bus high time follows the fastest one.

A separate bit/byte engine uses the single-cycle rise and fall strobes. It shifts SDA after a fall strobe and samples SDA after a rise strobe. A status bit shows when the block has finished its own low phase but the line is still held low by a peer. START/STOP generation, SDA handling and arbitration live elsewhere.

The low and high counts are in system clocks. Any value below 2 is treated as 2. Each count is captured when its phase begins. In the timings below, Leff and Heff are the effective counts.

Top module: `scl_sync_gen`

## Requirements
- R1: While reset is held and after it is released with enable low, scl_pull, rise_pulse, fall_pulse and stretch_wait are all 0.
- R2: With enable sampled high in the idle state, scl_pull is 1 from the next cycle. When enable is sampled low, scl_pull is 0 from the next cycle and the block returns to idle.
- R3: With no other master active, fall_pulse first rises 3 cycles after the clock edge that sampled enable. From each fall strobe to the next rise strobe is Leff+3 cycles.
- R4: If a peer still holds the line after the local low count ends, the block releases SCL and waits with stretch_wait high. It does not count its high phase during the wait. The rise strobe comes 2 cycles after the line is actually released.
- R5: The high count starts only once the synchronised line reads high. With no early peer edge, from a rise strobe to the next fall strobe is Heff+3 cycles.
- R6: A falling line edge seen during the high phase ends that phase at once. The fall strobe comes 2 cycles after the line falls. A full local low phase then starts from that edge.
- R7: When a peer's falling edge is seen in the same cycle that the local high count ends, exactly one low phase results. It is timed from the observed edge.
- R8: A low or high count below 2 behaves as a count of 2.
- R9: A new low count applied during a low phase does not change that phase, including its restart on the observed edge. It takes effect from the next low phase.
- R10: rise_pulse and fall_pulse each last one cycle. They are derived from the synchronised line level, 2 system clocks after the line changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; low returns to idle and releases SCL |
| low_count | input | 16 | Low-phase length in system clocks (min 2) |
| high_count | input | 16 | High-phase length in system clocks (min 2) |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_pull | output | 1 | 1 = pull SCL low, 0 = release |
| rise_pulse | output | 1 | One-cycle strobe on an observed SCL rising edge |
| fall_pulse | output | 1 | One-cycle strobe on an observed SCL falling edge |
| stretch_wait | output | 1 | High while released but waiting for SCL to go high |

## Verification
Two events can fall in the same cycle: the expiry of the local high count, and the arrival of a peer's falling edge at the synchroniser output. The bench's peer model pulls the line low a set delay after each rise strobe, chosen as Heff-2 cycles. That places the peer's edge on the exact cycle the own high count ends. The case is judged by two timings. The fall strobe must appear Heff cycles after the rise strobe, not Heff+3. The next rise strobe must follow exactly Leff+3 cycles later, which shows there was a single low phase with no double restart. An early peer edge and a peer that stretches the low phase are also run, and their strobe times are predicted from the line model.

// File: rtl/scl_sync_gen.sv
module scl_sync_gen #(
  parameter int CW      = 16,
  parameter int MIN_CNT = 2,
  parameter int SYNC    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [CW-1:0] low_count,
  input  logic [CW-1:0] high_count,
  input  logic          scl_in,
  output logic          scl_pull,
  output logic          rise_pulse,
  output logic          fall_pulse,
  output logic          stretch_wait
);

  localparam logic [CW-1:0] MINV = CW'(MIN_CNT);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HWAIT, S_HIGH} state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   lo_lat;
  logic [SYNC-1:0] sync_q;
  logic            scl_q;
  logic            scl_s;
  logic [CW-1:0]   lo_eff;
  logic [CW-1:0]   hi_eff;

  assign scl_s  = sync_q[SYNC-1];
  assign lo_eff = (low_count  < MINV) ? MINV : low_count;
  assign hi_eff = (high_count < MINV) ? MINV : high_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      scl_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], scl_in};
      scl_q  <= scl_s;
    end
  end

  assign fall_pulse = scl_q & ~scl_s;
  assign rise_pulse = ~scl_q & scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      lo_lat <= MINV;
    end else if (!enable) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          state  <= S_LOW;
          cnt    <= lo_eff - 1'b1;
          lo_lat <= lo_eff;
        end
        S_LOW: begin
          if (fall_pulse)
            cnt <= lo_lat - 1'b1;
          else if (!scl_s) begin
            if (cnt == '0) state <= S_HWAIT;
            else           cnt   <= cnt - 1'b1;
          end
        end
        S_HWAIT: begin
          if (scl_s) begin
            state <= S_HIGH;
            cnt   <= hi_eff - 1'b1;
          end
        end
        S_HIGH: begin
          if (fall_pulse || cnt == '0) begin
            state  <= S_LOW;
            cnt    <= lo_eff - 1'b1;
            lo_lat <= lo_eff;
          end else
            cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign scl_pull     = (state == S_LOW);
  assign stretch_wait = (state == S_HWAIT);

  a_r2_disable_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state == S_IDLE && !scl_pull));

  a_r3_low_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == S_LOW && cnt != '0) |=> scl_pull);

  a_r4_wait_stays_released: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == S_HWAIT && !scl_s) |=> (stretch_wait && !scl_pull));

  a_r5_high_only_after_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HIGH && $past(state) != S_HIGH) |-> $past(scl_s));

  a_r6_edge_ends_high: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && fall_pulse && state == S_HIGH) |=> (state == S_LOW && scl_pull));

endmodule

// File: tb/scl_sync_gen_test.sv
module scl_sync_gen_test;
  localparam int CLK_PERIOD = 10;

  typedef struct { bit is_rise; int at; } ev_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        enable = 0;
  logic [15:0] low_count = 16'd4;
  logic [15:0] high_count = 16'd4;
  logic        peer_pull = 0;
  logic        scl_line;
  logic        scl_pull, rise_pulse, fall_pulse, stretch_wait;

  int checks = 0, fails = 0, cyc = 0;
  int peer_mode = 0, peer_p = 0, peer_d = 0;
  int pdly = 0, phold = 0;
  bit mon_on = 0, prev_strobe = 0;
  string mon_tag = "";
  ev_t exp_q[$];

  assign scl_line = ~(scl_pull | peer_pull);

  scl_sync_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .low_count(low_count), .high_count(high_count),
    .scl_in(scl_line), .scl_pull(scl_pull),
    .rise_pulse(rise_pulse), .fall_pulse(fall_pulse),
    .stretch_wait(stretch_wait)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // peer master model on the shared line
  always @(negedge clk) begin
    if (peer_mode == 0) begin
      pdly = 0; phold = 0; peer_pull = 0;
    end else begin
      if (phold > 0) begin phold--; if (phold == 0) peer_pull = 0; end
      if (pdly > 0) begin
        pdly--;
        if (pdly == 0) begin peer_pull = 1; phold = 4; end
      end
      if (peer_mode == 1 && fall_pulse) begin peer_pull = 1; phold = peer_p; end
      if (peer_mode == 2 && rise_pulse) pdly = peer_d;
    end
  end

  // monitor: pops expected strobes and compares
  always @(negedge clk) begin
    if (rst_n && mon_on && (rise_pulse || fall_pulse)) begin
      check(!prev_strobe, {mon_tag, " R10 strobe width"}, 2, 1);
      if (exp_q.size() == 0)
        check(0, {mon_tag, " unexpected strobe"}, cyc, -1);
      else begin
        ev_t e;
        e = exp_q.pop_front();
        check(e.is_rise == rise_pulse, {mon_tag, " strobe kind"}, int'(rise_pulse), int'(e.is_rise));
        check(e.at == cyc, {mon_tag, " strobe cycle"}, cyc, e.at);
      end
    end
    prev_strobe = rise_pulse | fall_pulse;
  end

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic run(input string tag, input int mode, input int lin, input int hin,
                     input int p, input int d, input int nf, input int lnew);
    int le, he, ln, f, r, c0, ts;
    le = (lin < 2) ? 2 : lin;
    he = (hin < 2) ? 2 : hin;
    ln = (lnew < 2) ? 2 : lnew;
    @(negedge clk);
    c0 = cyc;
    low_count = 16'(lin); high_count = 16'(hin);
    peer_p = p; peer_d = d; peer_mode = mode;
    mon_tag = tag; mon_on = 1; enable = 1;
    f = c0 + 3;
    ts = c0 + 3 + le + 3;
    for (int i = 0; i < nf; i++) begin
      int l;
      l = (i == 0) ? le : ln;
      exp_q.push_back('{1'b0, f});
      r = (mode == 1 && p > l + 1) ? f + p + 2 : f + l + 3;
      exp_q.push_back('{1'b1, r});
      f = (mode == 2) ? r + d + 2 : r + he + 3;
    end
    @(negedge clk);
    check(scl_pull == 1'b1, {tag, " R2 pull after enable"}, int'(scl_pull), 1);
    wait_to(c0 + 3);
    low_count = 16'(lnew);
    if (mode == 1) begin
      wait_to(ts);
      check(stretch_wait == 1'b1 && !scl_pull, {tag, " R4 stretch wait"}, int'(stretch_wait), 1);
    end else if (mode == 0) begin
      wait_to(ts + 2);
      check(stretch_wait == 1'b0 && !scl_pull, {tag, " R5 high phase status"}, int'(stretch_wait), 0);
    end
    for (int t = 0; t < 3000 && exp_q.size() != 0; t++) @(negedge clk);
    check(exp_q.size() == 0, {tag, " missing strobes"}, exp_q.size(), 0);
    exp_q.delete();
    enable = 0; peer_mode = 0; mon_on = 0;
    @(negedge clk);
    check(scl_pull == 1'b0, {tag, " R2 release on disable"}, int'(scl_pull), 0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!scl_pull && !rise_pulse && !fall_pulse && !stretch_wait, "R1 in reset",
          int'({scl_pull, rise_pulse, fall_pulse, stretch_wait}), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!scl_pull && !rise_pulse && !fall_pulse && !stretch_wait, "R1 idle after reset",
          int'({scl_pull, rise_pulse, fall_pulse, stretch_wait}), 0);
    run("R3 R5 R10 alone", 0, 4, 3, 0, 0, 3, 4);
    run("R9 count change", 0, 5, 4, 0, 0, 3, 2);
    run("R8 minimum counts", 0, 0, 1, 0, 0, 2, 0);
    run("R4 stretched low", 1, 3, 3, 9, 0, 2, 3);
    run("R6 early peer edge", 2, 4, 8, 0, 2, 3, 4);
    run("R7 coincident edge", 2, 4, 8, 0, 6, 2, 4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule